// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a 20-bit physical address. It holds four 16-bit segment registers (code, data, stack, extra) and five 16-bit pointer registers (instruction pointer, source index, destination index, stack pointer, base pointer). A request names an offset source: one of the five pointers or an offset supplied on an input. The block picks the segment that goes with that source by default, unless an override input names a different segment. It then forms the address as the segment value shifted left by four bits plus the zero-extended offset, keeping only the low 20 bits.

The address is registered. It appears one clock after the request, together with a one-cycle valid strobe. Software-visible state is changed only through the two write ports: one for segments and one for pointers. A write in the same cycle as a request does not affect that request.

Top module: `seg_addr_gen`

## Requirements
- R1: The physical address equals (segment << 4) + zero-extended offset, taken modulo 2^20. Any carry out of bit 19 is dropped. For example, segment A4FB with offset 4872 gives A9822, and FFFF:FFFF gives 0FFEF.
- R2: After reset the code segment holds FFFF, and the data, stack and extra segments hold 0000. All five pointers hold 0000, `addr_valid` is 0 and `phys_addr` is 0. A request on the instruction pointer right after reset therefore yields FFFF0.
- R3: `off_sel` encodes the offset source and its default segment:
  - 0 is the instruction pointer, with the code segment.
  - 1 is the source index, with the data segment.
  - 2 is the destination index, with the extra segment.
  - 3 is the stack pointer, with the stack segment.
  - 4 is the base pointer, with the stack segment.
- R4: When `ovr_en` is 1, the segment named by `ovr_seg` replaces the default segment. The offset source stays the one chosen by `off_sel`.
- R5: `phys_addr` and `addr_valid` change one clock after a cycle with `req` high, and `addr_valid` is high for exactly that cycle. In a cycle after one without `req`, `addr_valid` is 0 and `phys_addr` keeps its value.
- R6: A register write and a request in the same cycle use the register's old value. The new value is used from the next request on.
- R7: A segment write stores `seg_wr_data` into the segment selected by `seg_wr_sel` (0 code, 1 data, 2 stack, 3 extra). A pointer write stores `ptr_wr_data` into the pointer at `ptr_wr_sel`, using the `off_sel` numbering 0..4. A pointer write with `ptr_wr_sel` of 5, 6 or 7 changes no register.
- R8: `off_sel` values 5, 6 and 7 take the offset from `ext_off` and pair it with the data segment by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Segment write enable |
| seg_wr_sel | input | 2 | Segment written (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | Segment write value |
| ptr_wr_en | input | 1 | Pointer write enable |
| ptr_wr_sel | input | 3 | Pointer written (0..4); other values ignored |
| ptr_wr_data | input | 16 | Pointer write value |
| req | input | 1 | Address request strobe |
| off_sel | input | 3 | Offset source (0..4 pointers, 5..7 external) |
| ext_off | input | 16 | External offset |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 2 | Segment used when override is enabled |
| phys_addr | output | 20 | Registered physical address |
| addr_valid | output | 1 | High one clock after a request |

## Verification
The bench sweeps every offset source against every override choice (including no override) under several register patterns, and compares each result against the arithmetic sum. A wrong default pairing, or an override that also switched the offset, would show up as a mismatch in that grid. Carry handling is probed with FFFF:FFFF and the A4FB:4872 pair: a design that widened or saturated the sum instead of wrapping would give 10FFEF or FFFFF. Same-cycle write-and-request probes catch a design that forwards the new value. Writes to pointer selects 5 to 7 are followed by a read of every pointer, which catches a decoder that aliases those codes onto a real register.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] RST_CODE_SEG = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_wr_en,
  input  logic [1:0]       seg_wr_sel,
  input  logic [SEG_W-1:0] seg_wr_data,
  input  logic             ptr_wr_en,
  input  logic [2:0]       ptr_wr_sel,
  input  logic [OFF_W-1:0] ptr_wr_data,
  input  logic             req,
  input  logic [2:0]       off_sel,
  input  logic [OFF_W-1:0] ext_off,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_seg,
  output logic [SEG_W+SHIFT-1:0] phys_addr,
  output logic             addr_valid
);
  localparam int PA_W = SEG_W + SHIFT;
  localparam logic [1:0] SG_CODE = 2'd0, SG_DATA = 2'd1, SG_STACK = 2'd2, SG_EXTRA = 2'd3;

  logic [SEG_W-1:0] seg_q [4];
  logic [OFF_W-1:0] ip_q, si_q, di_q, sp_q, bp_q;
  logic [OFF_W-1:0] off;
  logic [1:0]       dflt_seg, eff_seg;
  logic [PA_W-1:0]  base, sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q[SG_CODE]  <= RST_CODE_SEG;
      seg_q[SG_DATA]  <= '0;
      seg_q[SG_STACK] <= '0;
      seg_q[SG_EXTRA] <= '0;
    end else if (seg_wr_en) begin
      seg_q[seg_wr_sel] <= seg_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q <= '0; si_q <= '0; di_q <= '0; sp_q <= '0; bp_q <= '0;
    end else if (ptr_wr_en) begin
      case (ptr_wr_sel)
        3'd0: ip_q <= ptr_wr_data;
        3'd1: si_q <= ptr_wr_data;
        3'd2: di_q <= ptr_wr_data;
        3'd3: sp_q <= ptr_wr_data;
        3'd4: bp_q <= ptr_wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (off_sel)
      3'd0: begin off = ip_q; dflt_seg = SG_CODE;  end
      3'd1: begin off = si_q; dflt_seg = SG_DATA;  end
      3'd2: begin off = di_q; dflt_seg = SG_EXTRA; end
      3'd3: begin off = sp_q; dflt_seg = SG_STACK; end
      3'd4: begin off = bp_q; dflt_seg = SG_STACK; end
      default: begin off = ext_off; dflt_seg = SG_DATA; end
    endcase
  end

  assign eff_seg = ovr_en ? ovr_seg : dflt_seg;
  assign base    = {seg_q[eff_seg], {SHIFT{1'b0}}};
  assign sum     = base + {{(PA_W-OFF_W){1'b0}}, off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_addr  <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= req;
      if (req) phys_addr <= sum;
    end
  end
endmodule

module seg_addr_gen_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] RST_CODE_SEG = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seg_wr_en,
  input logic [1:0]       seg_wr_sel,
  input logic [SEG_W-1:0] seg_wr_data,
  input logic             req,
  input logic [2:0]       off_sel,
  input logic [OFF_W-1:0] ext_off,
  input logic             ovr_en,
  input logic [1:0]       ovr_seg,
  input logic [SEG_W+SHIFT-1:0] phys_addr,
  input logic             addr_valid
);
  localparam int PA_W = SEG_W + SHIFT;
  logic [SEG_W-1:0] shadow [4];
  logic [PA_W-1:0]  exp_ovr_q, exp_ds_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow[0] <= RST_CODE_SEG; shadow[1] <= '0; shadow[2] <= '0; shadow[3] <= '0;
      exp_ovr_q <= '0; exp_ds_q <= '0;
    end else begin
      if (seg_wr_en) shadow[seg_wr_sel] <= seg_wr_data;
      exp_ovr_q <= PA_W'({shadow[ovr_seg], {SHIFT{1'b0}}}) + PA_W'(ext_off);
      exp_ds_q  <= PA_W'({shadow[1], {SHIFT{1'b0}}}) + PA_W'(ext_off);
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) req |=> addr_valid); // R5
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) !req |=> !addr_valid); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !req |=> $stable(phys_addr)); // R5
  AST_EXT_OVERRIDE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req && off_sel >= 3'd5 && ovr_en) |=> phys_addr == exp_ovr_q); // R4
  AST_EXT_DEFAULT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req && off_sel >= 3'd5 && !ovr_en) |=> phys_addr == exp_ds_q); // R8
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .RST_CODE_SEG(RST_CODE_SEG)
) chk_i (
  .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
  .seg_wr_data(seg_wr_data), .req(req), .off_sel(off_sel), .ext_off(ext_off),
  .ovr_en(ovr_en), .ovr_seg(ovr_seg), .phys_addr(phys_addr), .addr_valid(addr_valid)
);

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic        ptr_wr_en = 1'b0;
  logic [2:0]  ptr_wr_sel = '0;
  logic [15:0] ptr_wr_data = '0;
  logic        req = 1'b0;
  logic [2:0]  off_sel = '0;
  logic [15:0] ext_off = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_seg = '0;
  logic [19:0] phys_addr;
  logic        addr_valid;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] seg_m [4];
  logic [15:0] ptr_m [5];

  always #2.5 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
    .seg_wr_data(seg_wr_data), .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel),
    .ptr_wr_data(ptr_wr_data), .req(req), .off_sel(off_sel), .ext_off(ext_off),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg), .phys_addr(phys_addr), .addr_valid(addr_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] calc(input logic [15:0] s, input logic [15:0] o);
    int unsigned t;
    t = (int'(s) * 16 + int'(o)) % 32'h100000;
    return t[19:0];
  endfunction

  function automatic logic [1:0] dflt(input logic [2:0] sel);
    case (sel)
      3'd0: return 2'd0;
      3'd1: return 2'd1;
      3'd2: return 2'd3;
      3'd3, 3'd4: return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk); seg_wr_en = 1; seg_wr_sel = s; seg_wr_data = v;
    @(negedge clk); seg_wr_en = 0;
    seg_m[s] = v;
  endtask

  task automatic wr_ptr(input logic [2:0] p, input logic [15:0] v);
    @(negedge clk); ptr_wr_en = 1; ptr_wr_sel = p; ptr_wr_data = v;
    @(negedge clk); ptr_wr_en = 0;
    if (p < 3'd5) ptr_m[p] = v;
  endtask

  task automatic do_req(input string tag, input logic [2:0] sel, input bit oe,
                        input logic [1:0] os, input logic [15:0] ext);
    logic [15:0] o;
    logic [1:0]  s;
    @(negedge clk);
    req = 1; off_sel = sel; ovr_en = oe; ovr_seg = os; ext_off = ext;
    o = (sel < 3'd5) ? ptr_m[sel] : ext;
    s = oe ? os : dflt(sel);
    @(negedge clk);
    req = 0;
    check({tag, " valid"}, 32'(addr_valid), 32'd1);
    check({tag, " addr"}, 32'(phys_addr), 32'(calc(seg_m[s], o)));
  endtask

  initial begin
    seg_m[0] = 16'hFFFF; seg_m[1] = 0; seg_m[2] = 0; seg_m[3] = 0;
    for (int i = 0; i < 5; i++) ptr_m[i] = 0;
    repeat (3) @(negedge clk);
    check("R2 reset valid", 32'(addr_valid), 0);
    check("R2 reset addr", 32'(phys_addr), 0);
    rst_n = 1;
    do_req("R2 ip after reset", 3'd0, 0, 0, 0);
    check("R2 FFFF0", 32'(phys_addr), 32'h0FFFF0);
    for (int s = 1; s < 4; s++) do_req("R2 other segs zero", 3'd5, 1, 2'(s), 16'h1234);

    // R5: idle cycle keeps address, drops valid
    @(negedge clk);
    check("R5 idle valid", 32'(addr_valid), 0);
    check("R5 hold addr", 32'(phys_addr), 32'(calc(seg_m[3], 16'h1234)));

    // R1 worked example and wrap
    wr_seg(2'd1, 16'hA4FB);
    do_req("R1 A4FB:4872", 3'd5, 0, 0, 16'h4872);
    check("R1 A9822", 32'(phys_addr), 32'h0A9822);
    wr_seg(2'd1, 16'hFFFF);
    do_req("R1 wrap", 3'd5, 0, 0, 16'hFFFF);
    check("R1 0FFEF", 32'(phys_addr), 32'h00FFEF);

    // R3 R4 R7 R8 sweep over three register patterns
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < 4; s++)
        wr_seg(2'(s), (p == 0) ? 16'(16'h1000 * (s + 1) + 16'h0011) :
                      (p == 1) ? 16'hFFFF - 16'(s) : 16'(16'h8421 ^ (s * 16'h1357)));
      for (int r = 0; r < 5; r++)
        wr_ptr(3'(r), (p == 0) ? 16'(16'h0100 * (r + 1) + 16'h000A) :
                      (p == 1) ? 16'hFFF0 + 16'(r) : 16'(16'hC3A5 ^ (r * 16'h0F1F)));
      for (int sel = 0; sel < 8; sel++)
        for (int ov = 0; ov < 5; ov++)
          do_req((ov == 4) ? "R3 R8 default pairing" : "R4 override",
                 3'(sel), ov != 4, 2'(ov), 16'(16'h7E01 + sel * 16'h2203 + p));
    end

    // R6: write and request in the same cycle
    @(negedge clk);
    req = 1; off_sel = 3'd0; ovr_en = 0;
    ptr_wr_en = 1; ptr_wr_sel = 3'd0; ptr_wr_data = 16'h5555;
    seg_wr_en = 1; seg_wr_sel = 2'd0; seg_wr_data = 16'h2222;
    @(negedge clk);
    req = 0; ptr_wr_en = 0; seg_wr_en = 0;
    check("R6 old values used", 32'(phys_addr), 32'(calc(seg_m[0], ptr_m[0])));
    seg_m[0] = 16'h2222; ptr_m[0] = 16'h5555;
    do_req("R6 new values next", 3'd0, 0, 0, 0);
    check("R6 22220+5555", 32'(phys_addr), 32'h027775);

    // R7: writes to pointer selects 5..7 touch nothing
    for (int k = 5; k < 8; k++) wr_ptr(3'(k), 16'hDEAD);
    for (int r = 0; r < 5; r++) do_req("R7 ignored ptr write", 3'(r), 1, 2'd2, 16'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule